// File: doc/BRIEF.md
# REQ/ACK DMA Handshake Sequencer

This block drives the peripheral side of a request/acknowledge DMA handshake next to a pair of FIFOs. When the attached device raises its request, the sequencer waits a programmed number of internal clocks. It then asserts acknowledge, followed by either an Intel-style read or write strobe, or a Motorola-style data strobe with a read/write line. At the end of each word it pulses a pop or push towards the FIFO that moved the data. A request that is still held at the end of a word starts the next word at once, without waiting through the latency again.

All timing runs on an internal clock. That clock equals the input clock, or the input clock divided by two. The following are set by static configuration inputs:

- the request-to-acknowledge latency, 2 to 5 internal clocks;
- the strobe width, 1 or 2 internal clocks;
- the request polarity and the acknowledge polarity;
- the bus style.

The sequencer never acknowledges a read while the outbound FIFO is empty, or a write while the inbound FIFO is full. It holds instead until the FIFO can serve. A synchronous clear returns it to idle.

Top module: `dma_hs_seq`

## Requirements
- R1: While `cfg_periph` is 0 the request is ignored: acknowledge stays inactive, `rd_n`, `wr_n`, `ds_n` and `rnw` stay 1, and `pop` and `push` stay 0.
- R2: With `cfg_lat` = L and the clock not divided, acknowledge becomes active L+2 clock edges after the edge that first samples an active request from idle.
- R3: The strobe asserts one internal clock after acknowledge and lasts 1 internal clock when `cfg_wide` = 0, or 2 internal clocks when `cfg_wide` = 1.
- R4: With `cfg_div2` = 1 the internal clock is every second input clock. All latency, acknowledge-to-strobe and strobe-width intervals then double in input clocks.
- R5: The request is active high when `cfg_req_low` = 0 and active low when it is 1. Acknowledge is active low when `cfg_ack_high` = 0 and active high when it is 1.
- R6: Intel style (`cfg_moto` = 0), all strobes active low: a read (`dir_rd` = 1) pulses `rd_n` and a write (`dir_rd` = 0) pulses `wr_n`. The unused strobe and `ds_n` stay 1.
- R7: Motorola style (`cfg_moto` = 1): `rnw` equals `dir_rd` from the first cycle of acknowledge, and the strobe appears on `ds_n` (active low). `rd_n` and `wr_n` stay 1, and `rnw` idles at 1.
- R8: Acknowledge and strobe go inactive on the same edge. On that edge `pop` (read) or `push` (write) becomes 1 for exactly one input clock, and the other stays 0.
- R9: While the selected FIFO is blocked (`tx_empty` for reads, `rx_full` for writes), acknowledge is withheld. Once the block clears with the request still active, acknowledge asserts on the next internal clock.
- R10: If the request is still active when a word ends, acknowledge is inactive for exactly one internal clock and then asserts again without the programmed latency.
- R11: A `seq_clr` pulse returns the sequencer to idle. On the next cycle, acknowledge, all strobes, `pop` and `push` are inactive.
- R12: After `rst_n` with every configuration input at 0, `ack_out` is 1 (inactive), `rd_n`, `wr_n`, `ds_n` and `rnw` are 1, and `pop` and `push` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seq_clr | input | 1 | Synchronous return to idle |
| cfg_periph | input | 1 | Enables the sequencer |
| cfg_div2 | input | 1 | Internal clock is clk divided by 2 |
| cfg_lat | input | LAT_BITS | Request-to-acknowledge latency code, delay = code + 2 |
| cfg_wide | input | 1 | Strobe lasts 2 internal clocks |
| cfg_req_low | input | 1 | Request is active low |
| cfg_ack_high | input | 1 | Acknowledge is active high |
| cfg_moto | input | 1 | Data strobe plus read/write line instead of read/write strobes |
| req_in | input | 1 | Transfer request from the device |
| dir_rd | input | 1 | 1 = device reads (pop), 0 = device writes (push) |
| tx_empty | input | 1 | Outbound FIFO empty |
| rx_full | input | 1 | Inbound FIFO full |
| ack_out | output | 1 | Acknowledge, polarity per cfg_ack_high |
| rd_n | output | 1 | Intel read strobe, active low |
| wr_n | output | 1 | Intel write strobe, active low |
| ds_n | output | 1 | Motorola data strobe, active low |
| rnw | output | 1 | Motorola read/write line, 1 = read |
| pop | output | 1 | One-cycle pop of the outbound FIFO |
| push | output | 1 | One-cycle push into the inbound FIFO |

## Verification
A wrong state or counter value shows within a few internal clocks as a shifted acknowledge edge, a strobe of the wrong length, or a pop or push that fires without, or apart from, a strobe fall. The bench therefore measures every interval in input clocks against the configured values, for both bus styles and both clock rates. A stuck hold state shows as an acknowledge that never comes, or comes while the FIFO is blocked. A missing return to idle shows as an extra acknowledge after the request has dropped or after a clear.

// File: rtl/dma_hs_seq.sv
module dma_hs_seq #(
  parameter int LAT_BITS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                seq_clr,
  input  logic                cfg_periph,
  input  logic                cfg_div2,
  input  logic [LAT_BITS-1:0] cfg_lat,
  input  logic                cfg_wide,
  input  logic                cfg_req_low,
  input  logic                cfg_ack_high,
  input  logic                cfg_moto,
  input  logic                req_in,
  input  logic                dir_rd,
  input  logic                tx_empty,
  input  logic                rx_full,
  output logic                ack_out,
  output logic                rd_n,
  output logic                wr_n,
  output logic                ds_n,
  output logic                rnw,
  output logic                pop,
  output logic                push
);
  localparam int MAX_LAT = (1 << LAT_BITS) + 1;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_HOLD, S_ACK, S_STB, S_REARM} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic             phase, sw, dir_q;

  wire              tick    = ~cfg_div2 | phase;
  wire              req_act = req_in ^ cfg_req_low;
  wire              blk_in  = dir_rd ? tx_empty : rx_full;
  wire              blk_q   = dir_q ? tx_empty : rx_full;
  wire [CNT_W-1:0]  lat_n   = CNT_W'(cfg_lat) + CNT_W'(2);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                         phase <= 1'b0;
    else if (seq_clr || !cfg_div2)      phase <= 1'b0;
    else                                phase <= ~phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sw <= 1'b0; dir_q <= 1'b0; pop <= 1'b0; push <= 1'b0;
    end else if (seq_clr || !cfg_periph) begin
      st <= S_IDLE; cnt <= '0; sw <= 1'b0; pop <= 1'b0; push <= 1'b0;
    end else begin
      pop  <= 1'b0;
      push <= 1'b0;
      if (tick) begin
        case (st)
          S_IDLE:
            if (req_act) begin
              dir_q <= dir_rd;
              if (blk_in) st <= S_HOLD;
              else begin st <= S_WAIT; cnt <= CNT_W'(1); end
            end
          S_WAIT:
            if (!req_act)          st <= S_IDLE;
            else if (cnt == lat_n) st <= blk_q ? S_HOLD : S_ACK;
            else                   cnt <= cnt + CNT_W'(1);
          S_HOLD:
            if (!req_act)   st <= S_IDLE;
            else if (!blk_q) st <= S_ACK;
          S_ACK: begin
            st <= S_STB;
            sw <= 1'b0;
          end
          S_STB:
            if (cfg_wide && !sw) sw <= 1'b1;
            else begin
              st   <= S_REARM;
              pop  <= dir_q;
              push <= ~dir_q;
            end
          S_REARM:
            if (req_act) begin
              dir_q <= dir_rd;
              st    <= blk_in ? S_HOLD : S_ACK;
            end else st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  wire ack_on = (st == S_ACK) || (st == S_STB);
  wire stb_on = (st == S_STB);

  assign ack_out = cfg_ack_high ? ack_on : ~ack_on;
  assign rd_n    = ~(stb_on & ~cfg_moto & dir_q);
  assign wr_n    = ~(stb_on & ~cfg_moto & ~dir_q);
  assign ds_n    = ~(stb_on & cfg_moto);
  assign rnw     = ~(ack_on & cfg_moto & ~dir_q);
endmodule

// File: rtl/dma_hs_seq_chk.sv
module dma_hs_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic seq_clr,
  input logic cfg_periph,
  input logic cfg_ack_high,
  input logic dir_rd,
  input logic tx_empty,
  input logic rx_full,
  input logic ack_out,
  input logic rd_n,
  input logic wr_n,
  input logic ds_n,
  input logic pop,
  input logic push
);
  wire ack_act = cfg_ack_high ? ack_out : ~ack_out;
  wire stb     = ~rd_n | ~wr_n | ~ds_n;

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~rd_n, ~wr_n, ~ds_n}));

  // R3
  stb_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> ack_act);

  // R8
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stb) |-> !ack_act);

  // R8
  pulse_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop || push) |-> ($past(stb) && !stb && !(pop && push)));

  // R1
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cfg_periph) |-> (!ack_act && !stb && !pop && !push));

  // R9
  no_blk_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ack_act) && $stable(dir_rd)) |-> $past(dir_rd ? !tx_empty : !rx_full));

  // R11
  clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(seq_clr) |-> (!ack_act && !stb && !pop && !push));
endmodule

bind dma_hs_seq dma_hs_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .seq_clr(seq_clr), .cfg_periph(cfg_periph),
  .cfg_ack_high(cfg_ack_high), .dir_rd(dir_rd), .tx_empty(tx_empty), .rx_full(rx_full),
  .ack_out(ack_out), .rd_n(rd_n), .wr_n(wr_n), .ds_n(ds_n), .pop(pop), .push(push)
);

// File: tb/tb_dma_hs_seq.sv
module tb_dma_hs_seq;
  logic clk = 0, rst_n = 0, seq_clr = 0;
  logic cfg_periph = 0, cfg_div2 = 0, cfg_wide = 0, cfg_req_low = 0, cfg_ack_high = 0, cfg_moto = 0;
  logic [1:0] cfg_lat = 0;
  logic req_in = 0, dir_rd = 0, tx_empty = 0, rx_full = 0;
  logic ack_out, rd_n, wr_n, ds_n, rnw, pop, push;
  int n_run = 0, n_fail = 0;

  dma_hs_seq dut (.*);

  always #4 clk = ~clk;

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic chk_rng(input string rq, input string what, input int act, input int lo, input int hi);
    n_run++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", rq, what, act, lo, hi);
    end
  endtask

  function automatic bit ack_on();
    return cfg_ack_high ? ack_out : !ack_out;
  endfunction
  function automatic bit stb_on();
    return !rd_n || !wr_n || !ds_n;
  endfunction
  task automatic set_req(input bit a);
    req_in = a ^ cfg_req_low;
  endtask

  task automatic set_cfg(input bit dv, input int lat, input bit wide, input bit moto);
    @(negedge clk);
    cfg_periph = 1; cfg_div2 = dv; cfg_lat = 2'(lat); cfg_wide = wide; cfg_moto = moto;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_xfer(input bit rd, input string rq);
    int lat, a2s, w, dv, n;
    dv = cfg_div2 ? 2 : 1;
    n  = int'(cfg_lat) + 2;
    @(negedge clk);
    dir_rd = rd; set_req(1);
    lat = 0;
    while (!ack_on() && lat < 200) begin @(negedge clk); lat++; end
    if (dv == 1) chk(rq, "latency", lat, n + 1);
    else         chk_rng(rq, "latency div2", lat, 2*n + 1, 2*n + 2);
    if (cfg_moto) chk("R7", "rnw at ack", int'(rnw), int'(rd));
    a2s = 0;
    while (!stb_on() && a2s < 50) begin @(negedge clk); a2s++; end
    chk(rq, "ack to strobe", a2s, dv);
    if (cfg_moto) begin
      chk("R7", "ds_n", int'(ds_n), 0);
      chk("R7", "rd_n/wr_n idle", int'(rd_n & wr_n), 1);
      chk("R7", "rnw at strobe", int'(rnw), int'(rd));
    end else begin
      chk("R6", "rd_n", int'(rd_n), rd ? 0 : 1);
      chk("R6", "wr_n", int'(wr_n), rd ? 1 : 0);
      chk("R6", "ds_n idle", int'(ds_n), 1);
    end
    w = 0;
    while (stb_on() && w < 50) begin @(negedge clk); w++; end
    chk(rq, "strobe width", w, (cfg_wide ? 2 : 1) * dv);
    chk("R8", "ack with strobe end", int'(ack_on()), 0);
    chk("R8", "pop", int'(pop), int'(rd));
    chk("R8", "push", int'(push), int'(!rd));
    set_req(0);
    @(negedge clk);
    chk("R8", "pulse one cycle", int'(pop | push), 0);
    repeat (6) @(negedge clk);
    chk(rq, "idle after drop", int'(ack_on()), 0);
  endtask

  task automatic t_reset();
    chk("R12", "ack_out", int'(ack_out), 1);
    chk("R12", "strobes", int'(rd_n & wr_n & ds_n & rnw), 1);
    chk("R12", "pop/push", int'(pop | push), 0);
  endtask

  task automatic t_periph_off();
    int bad = 0;
    @(negedge clk);
    cfg_periph = 0; dir_rd = 1; set_req(1);
    repeat (20) begin
      @(negedge clk);
      if (ack_on() || stb_on() || pop || push || !rnw) bad++;
    end
    chk("R1", "active outputs while off", bad, 0);
    set_req(0);
  endtask

  task automatic t_latency();
    for (int l = 0; l < 4; l++) begin
      set_cfg(0, l, 0, 0);
      do_xfer(1, "R2");
    end
  endtask

  task automatic t_width();
    set_cfg(0, 0, 1, 0);
    do_xfer(1, "R3");
    do_xfer(0, "R3");
    set_cfg(0, 2, 0, 0);
    do_xfer(0, "R6");
  endtask

  task automatic t_moto();
    set_cfg(0, 1, 0, 1);
    @(negedge clk);
    chk("R7", "rnw idle", int'(rnw), 1);
    do_xfer(0, "R7");
    do_xfer(1, "R7");
    set_cfg(0, 0, 0, 0);
  endtask

  task automatic t_div2();
    set_cfg(1, 0, 0, 0);
    do_xfer(1, "R4");
    set_cfg(1, 3, 1, 1);
    do_xfer(0, "R4");
    set_cfg(0, 0, 0, 0);
  endtask

  task automatic t_polarity();
    int bad = 0;
    @(negedge clk);
    cfg_req_low = 1; cfg_ack_high = 1; req_in = 1;
    repeat (10) begin @(negedge clk); if (ack_out) bad++; end
    chk("R5", "high req ignored when active low", bad, 0);
    do_xfer(1, "R5");
    chk("R5", "ack idle level high polarity", int'(ack_out), 0);
    @(negedge clk);
    cfg_req_low = 0; cfg_ack_high = 0; req_in = 0;
    repeat (2) @(negedge clk);
    chk("R5", "ack idle level low polarity", int'(ack_out), 1);
  endtask

  task automatic t_blocked(input bit rd);
    int bad = 0;
    set_cfg(0, 0, 0, 0);
    @(negedge clk);
    dir_rd = rd;
    if (rd) tx_empty = 1; else rx_full = 1;
    set_req(1);
    repeat (20) begin @(negedge clk); if (ack_on() || pop || push) bad++; end
    chk("R9", "ack while blocked", bad, 0);
    tx_empty = 0; rx_full = 0;
    @(negedge clk);
    chk("R9", "ack after release", int'(ack_on()), 1);
    set_req(0);
    while (ack_on()) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_burst();
    int guard = 0;
    set_cfg(0, 1, 0, 0);
    @(negedge clk);
    dir_rd = 0; set_req(1);
    while (!stb_on() && guard < 100) begin @(negedge clk); guard++; end
    while (stb_on() && guard < 100) begin @(negedge clk); guard++; end
    chk("R10", "ack gap", int'(ack_on()), 0);
    chk("R10", "push at end", int'(push), 1);
    @(negedge clk);
    chk("R10", "ack back without latency", int'(ack_on()), 1);
    set_req(0);
    while (ack_on() && guard < 100) begin @(negedge clk); guard++; end
    chk("R10", "second push", int'(push), 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_clear();
    int guard = 0, bad = 0;
    set_cfg(0, 0, 1, 0);
    @(negedge clk);
    dir_rd = 1; set_req(1);
    while (!stb_on() && guard < 100) begin @(negedge clk); guard++; end
    seq_clr = 1; set_req(0);
    @(negedge clk);
    seq_clr = 0;
    chk("R11", "ack after clear", int'(ack_on()), 0);
    chk("R11", "strobes after clear", int'(rd_n & wr_n & ds_n), 1);
    chk("R11", "pop after clear", int'(pop | push), 0);
    repeat (8) begin @(negedge clk); if (ack_on() || pop) bad++; end
    chk("R11", "stays idle", bad, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_periph_off();
    t_latency();
    t_width();
    t_moto();
    t_div2();
    t_polarity();
    t_blocked(1);
    t_blocked(0);
    t_burst();
    t_clear();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule